// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block keeps a small bank of accumulator registers and lets several requesters perform fetch-and-add on them in the same clock cycle. Each request port names one accumulator and supplies an increment. The port gets back the value the accumulator held just before that port's own increment was applied. The accumulator then moves on by the increment. A common use is to hand out unique, consecutive slot numbers or thread identifiers with an increment of one.

When several ports target the same accumulator in one cycle, the unit does not serialise them. It forms a single prefix chain over those ports, ordered by port index with the lowest first. Every port receives its own partial sum, and the accumulator takes the full total. Ports that target different accumulators in the same cycle are handled by independent chains. A load port lets a controlling master overwrite any accumulator. A load stalls all requests for that cycle.

Each request port is a valid/ready stream input. A request is accepted on a rising edge where both valid and ready are high. Ready is low exactly in the cycles where the load port is active. A requester that sees ready low must hold its request and try again. Responses cannot be back-pressured. The response for an accepted request appears as a one-cycle valid pulse, exactly one cycle after acceptance, on the same port.

Top module: `prefix_sum_unit`

## Requirements
- R1: After reset every accumulator reads as zero and no response valid is high.
- R2: A lone accepted request returns the accumulator's prior value. The accumulator then holds the prior value plus the increment.
- R3: Accepted requests to one accumulator in one cycle are ordered by ascending port index. The port at position i receives the prior value plus the increments of all lower-indexed ports that target the same accumulator.
- R4: After a combined cycle, the accumulator holds its prior value plus the sum of all increments accepted for it.
- R5: Requests in the same cycle that target different accumulators do not affect each other's results or totals.
- R6: The response valid on port p is high exactly one cycle after a request was accepted on port p, and low otherwise. The update is visible to requests accepted in the next cycle.
- R7: All additions wrap modulo 2^W. There is no overflow indication.
- R8: When the load port is valid, every request ready is low and no request is accepted. In the next cycle the chosen accumulator holds the load value.
- R9: When the load port is idle, every request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPORT | Per-port request valid |
| req_ready | output | NPORT | Per-port request ready |
| req_sel | input | NPORT*SELW | Accumulator index per port, port p in bits [p*SELW +: SELW] |
| req_incr | input | NPORT*W | Increment per port, port p in bits [p*W +: W] |
| rsp_valid | output | NPORT | Per-port response pulse |
| rsp_prior | output | NPORT*W | Value before this port's increment, port p in bits [p*W +: W] |
| load_valid | input | 1 | Load accumulator strobe |
| load_sel | input | SELW | Accumulator index to load |
| load_value | input | W | Value to load |

## Verification
The bench builds the block with its default parameters: four ports, four accumulators and a 16-bit width. With four ports, a single cycle can contain a four-deep chain on one accumulator, two interleaved chains, and chains whose members are not on adjacent ports. With four accumulators, a chain can run next to a target that stays untouched. The 16-bit width lets a loaded value near the top of the range wrap within one chain. A random phase mixes all of these patterns with loads.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_SUM  = 2'd2
  } upd_e;
endpackage

// File: rtl/psu_prefix_chain.sv
module psu_prefix_chain #(
  parameter int NPORT = 4,
  parameter int W     = 16
) (
  input  logic [W-1:0]       base,
  input  logic [NPORT-1:0]   hit,
  input  logic [NPORT*W-1:0] incr,
  output logic [NPORT*W-1:0] part,
  output logic [W-1:0]       total,
  output logic               any_hit
);
  logic [W-1:0] acc;

  always_comb begin
    acc  = base;
    part = '0;
    for (int p = 0; p < NPORT; p++) begin
      part[p*W +: W] = acc;
      if (hit[p]) acc = acc + incr[p*W +: W];
    end
    total   = acc;
    any_hit = |hit;
  end
endmodule

// File: rtl/psu_base_cell.sv
module psu_base_cell
  import psu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_value,
  input  logic         sum_en,
  input  logic [W-1:0] sum_value,
  output logic [W-1:0] q
);
  upd_e mode;

  always_comb begin
    if (ld_en)       mode = UPD_LOAD;
    else if (sum_en) mode = UPD_SUM;
    else             mode = UPD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      case (mode)
        UPD_LOAD: q <= ld_value;
        UPD_SUM:  q <= sum_value;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/psu_resp_stage.sv
module psu_resp_stage #(
  parameter int NPORT = 4,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   take,
  input  logic [NPORT*W-1:0] prior_d,
  output logic [NPORT-1:0]   rsp_valid,
  output logic [NPORT*W-1:0] rsp_prior
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_prior <= '0;
    end else begin
      rsp_valid <= take;
      for (int p = 0; p < NPORT; p++)
        if (take[p]) rsp_prior[p*W +: W] <= prior_d[p*W +: W];
    end
  end
endmodule

// File: rtl/prefix_sum_unit.sv
module prefix_sum_unit #(
  parameter int NPORT = 4,
  parameter int NBASE = 4,
  parameter int W     = 16,
  localparam int SELW = (NBASE > 1) ? $clog2(NBASE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      req_valid,
  output logic [NPORT-1:0]      req_ready,
  input  logic [NPORT*SELW-1:0] req_sel,
  input  logic [NPORT*W-1:0]    req_incr,
  output logic [NPORT-1:0]      rsp_valid,
  output logic [NPORT*W-1:0]    rsp_prior,
  input  logic                  load_valid,
  input  logic [SELW-1:0]       load_sel,
  input  logic [W-1:0]          load_value
);
  logic [NPORT-1:0]   take;
  logic [NPORT*W-1:0] part_all [NBASE];
  logic [NPORT*W-1:0] prior_d;

  assign req_ready = {NPORT{~load_valid}};
  assign take      = req_valid & req_ready;

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    logic [NPORT-1:0] hit;
    logic [W-1:0]     cur;
    logic [W-1:0]     total;
    logic             any_hit;

    for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hit[p] = take[p] && (req_sel[p*SELW +: SELW] == SELW'(b));
    end

    psu_prefix_chain #(.NPORT(NPORT), .W(W)) u_chain (
      .base    (cur),
      .hit     (hit),
      .incr    (req_incr),
      .part    (part_all[b]),
      .total   (total),
      .any_hit (any_hit)
    );

    psu_base_cell #(.W(W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (load_valid && (load_sel == SELW'(b))),
      .ld_value  (load_value),
      .sum_en    (any_hit),
      .sum_value (total),
      .q         (cur)
    );
  end

  always_comb begin
    prior_d = '0;
    for (int p = 0; p < NPORT; p++)
      for (int b = 0; b < NBASE; b++)
        if (req_sel[p*SELW +: SELW] == SELW'(b))
          prior_d[p*W +: W] = part_all[b][p*W +: W];
  end

  psu_resp_stage #(.NPORT(NPORT), .W(W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .prior_d   (prior_d),
    .rsp_valid (rsp_valid),
    .rsp_prior (rsp_prior)
  );
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int NPORT = 4,
  parameter int W     = 16,
  parameter int SELW  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPORT-1:0]      req_valid,
  input logic [NPORT-1:0]      req_ready,
  input logic [NPORT*SELW-1:0] req_sel,
  input logic [NPORT*W-1:0]    req_incr,
  input logic [NPORT-1:0]      rsp_valid,
  input logic [NPORT*W-1:0]    rsp_prior,
  input logic                  load_valid
);
  assert_rsp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid & req_ready));

  assert_load_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> req_ready == '0);

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> &req_ready);

  for (genvar p = 0; p + 1 < NPORT; p++) begin : g_pair
    assert_chain_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_valid[p+1] && req_ready[p] && req_ready[p+1] &&
       req_sel[p*SELW +: SELW] == req_sel[(p+1)*SELW +: SELW])
      |=> rsp_prior[(p+1)*W +: W] == W'(rsp_prior[p*W +: W] + $past(req_incr[p*W +: W])));
  end
endmodule

bind prefix_sum_unit psu_checker #(.NPORT(NPORT), .W(W), .SELW(SELW)) u_psu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_sel    (req_sel),
  .req_incr   (req_incr),
  .rsp_valid  (rsp_valid),
  .rsp_prior  (rsp_prior),
  .load_valid (load_valid)
);

// File: tb/tb_prefix_sum_unit.sv
module tb_prefix_sum_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 4;
  localparam int NBASE = 4;
  localparam int W     = 16;
  localparam int SELW  = 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NPORT-1:0]      req_valid = '0;
  logic [NPORT-1:0]      req_ready;
  logic [NPORT*SELW-1:0] req_sel = '0;
  logic [NPORT*W-1:0]    req_incr = '0;
  logic [NPORT-1:0]      rsp_valid;
  logic [NPORT*W-1:0]    rsp_prior;
  logic                  load_valid = 1'b0;
  logic [SELW-1:0]       load_sel = '0;
  logic [W-1:0]          load_value = '0;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] mdl [NBASE];
  logic         s_v [NPORT];
  int           s_b [NPORT];
  logic [W-1:0] s_i [NPORT];

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_sum_unit #(.NPORT(NPORT), .NBASE(NBASE), .W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_incr(req_incr),
    .rsp_valid(rsp_valid), .rsp_prior(rsp_prior),
    .load_valid(load_valid), .load_sel(load_sel), .load_value(load_value)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_slots();
    for (int p = 0; p < NPORT; p++) begin
      s_v[p] = 1'b0; s_b[p] = 0; s_i[p] = '0;
    end
  endtask

  // Drive one cycle of stimulus from the slots, predict, and check one edge later.
  task automatic run_cycle(input string tag, input bit ld, input int ld_b, input logic [W-1:0] ld_d);
    logic         ev [NPORT];
    logic [W-1:0] ed [NPORT];
    for (int p = 0; p < NPORT; p++) begin
      req_valid[p] = s_v[p];
      req_sel[p*SELW +: SELW] = SELW'(s_b[p]);
      req_incr[p*W +: W] = s_i[p];
    end
    load_valid = ld; load_sel = SELW'(ld_b); load_value = ld_d;
    #1;
    for (int p = 0; p < NPORT; p++)
      check(ld ? "R8 ready" : "R9 ready", req_ready[p], ld ? 0 : 1);
    for (int p = 0; p < NPORT; p++) begin
      ev[p] = s_v[p] && !ld;
      ed[p] = '0;
      if (ev[p]) begin
        ed[p] = mdl[s_b[p]];
        mdl[s_b[p]] = mdl[s_b[p]] + s_i[p];
      end
    end
    if (ld) mdl[ld_b] = ld_d;
    @(posedge clk);
    #(CLK_PERIOD/2);
    for (int p = 0; p < NPORT; p++) begin
      check({tag, " R6 valid"}, rsp_valid[p], ev[p]);
      if (ev[p]) check(tag, rsp_prior[p*W +: W], ed[p]);
    end
    req_valid = '0;
    load_valid = 1'b0;
  endtask

  // Read every accumulator with zero increments, one port each.
  task automatic read_all(input string tag);
    clear_slots();
    for (int p = 0; p < NPORT; p++) begin
      s_v[p] = 1'b1; s_b[p] = p % NBASE; s_i[p] = '0;
    end
    run_cycle(tag, 1'b0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < NBASE; b++) mdl[b] = '0;
    clear_slots();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    read_all("R1 reset value");

    // R2 single request
    clear_slots(); s_v[0] = 1; s_b[0] = 1; s_i[0] = 16'd5;
    run_cycle("R2 single", 1'b0, 0, '0);
    read_all("R2 after single");

    // R3 four ports on one accumulator, slot numbering
    clear_slots();
    for (int p = 0; p < NPORT; p++) begin s_v[p] = 1; s_b[p] = 2; s_i[p] = 16'd1; end
    run_cycle("R3 chain", 1'b0, 0, '0);
    read_all("R4 total");

    // R3 non-adjacent members with distinct increments
    clear_slots();
    s_v[0] = 1; s_b[0] = 0; s_i[0] = 16'd7;
    s_v[1] = 1; s_b[1] = 3; s_i[1] = 16'd100;
    s_v[3] = 1; s_b[3] = 0; s_i[3] = 16'd9;
    run_cycle("R3 gap R5 mixed", 1'b0, 0, '0);
    read_all("R4 R5 totals");

    // R5 two interleaved chains
    clear_slots();
    s_v[0] = 1; s_b[0] = 1; s_i[0] = 16'd2;
    s_v[1] = 1; s_b[1] = 2; s_i[1] = 16'd3;
    s_v[2] = 1; s_b[2] = 1; s_i[2] = 16'd4;
    s_v[3] = 1; s_b[3] = 2; s_i[3] = 16'd5;
    run_cycle("R5 interleave", 1'b0, 0, '0);
    read_all("R5 totals");

    // R8 load with competing requests, then R7 wrap
    clear_slots();
    for (int p = 0; p < NPORT; p++) begin s_v[p] = 1; s_b[p] = 3; s_i[p] = 16'd1; end
    run_cycle("R8 load stall", 1'b1, 3, 16'hFFFE);
    clear_slots();
    s_v[0] = 1; s_b[0] = 3; s_i[0] = 16'd1;
    s_v[1] = 1; s_b[1] = 3; s_i[1] = 16'd1;
    s_v[2] = 1; s_b[2] = 3; s_i[2] = 16'd5;
    run_cycle("R7 wrap", 1'b0, 0, '0);
    read_all("R7 wrapped total");

    // back-to-back visibility (R6)
    clear_slots(); s_v[2] = 1; s_b[2] = 0; s_i[2] = 16'd11;
    run_cycle("R6 first", 1'b0, 0, '0);
    run_cycle("R6 second", 1'b0, 0, '0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      bit ld;
      clear_slots();
      for (int p = 0; p < NPORT; p++) begin
        s_v[p] = $urandom_range(0, 3) != 0;
        s_b[p] = $urandom_range(0, NBASE-1);
        s_i[p] = ($urandom_range(0, 3) == 0) ? W'($urandom) : W'($urandom_range(0, 3));
      end
      ld = $urandom_range(0, 7) == 0;
      run_cycle("R3 random", ld, $urandom_range(0, NBASE-1), W'($urandom));
    end
    read_all("R4 random totals");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule